// File: doc/BRIEF.md
# In-Order Multi-Retire Completion Queue

This block keeps a circular record of every instruction that dispatch hands to the execution units, in program order, and lets them leave again strictly oldest-first. Each record is tagged with its 4-bit slot number. Execution units report back by tag when work is done, and may mark the result as faulting. The branch unit reports each branch outcome by tag. The queue then releases a contiguous group of up to three finished, fault-free records from the oldest end on every clock.

When a branch turns out to be mispredicted, every record younger than it is discarded and the block tells the front end where the cut lies. When the oldest record carries a fault, nothing retires, the whole queue is emptied and a one-cycle exception pulse is raised.

Allocation is a valid/ready stream, up to three lanes wide. A lane is taken only on a clock edge where its `alloc_valid` bit and `alloc_ready` are both high. `alloc_ready` may depend on the lanes requested and on their branch flags in the same cycle. A requester must hold its lanes steady until they are accepted. Finish and branch reports, the retire outputs and the flush/exception outputs are plain pulses with no back-pressure: retirement can never be stalled from outside.

Top module: `completion_queue`

## Requirements
- R1: The queue holds 16 records. `free_cnt` equals 16 minus the number of records held, and it changes only after the clock edge that changes occupancy.
- R2: A record retires only when it has finished, carries no fault, and every older record has retired or is retiring in the same cycle.
- R3: At most three records retire per cycle. `ret_valid` is always a run of ones starting at bit 0. `ret_tag` is the tag on lane 0, and lane i retires tag `ret_tag`+i modulo 16.
- R4: A branch report marks its branch finished and resolved. If `br_mispredict` is set, then in the next cycle `flush_valid`=1, `flush_all`=0 and `flush_tag` is the branch's tag. All younger records are gone, while the branch itself stays.
- R5: An allocation accepts the set lanes of `alloc_valid`. Lanes are packed in lane order onto consecutive tags starting at `alloc_tag`, which wraps from 15 to 0.
- R6: `alloc_ready` is low when the number of requested lanes exceeds `free_cnt`, and in any cycle that carries a mispredict or a faulting oldest record.
- R7: When the oldest record has finished with `fin_exc`=1, nothing retires. One cycle later `exc_valid`, `flush_valid` and `flush_all` pulse high for exactly one cycle, with `flush_tag` set to that record's tag, and the queue is empty.
- R8: At most three branch records (lanes with `alloc_is_br`=1) may be unresolved at once. `alloc_ready` is low when a request would exceed that limit.
- R9: A finish report for a record that is being discarded by a flush in the same cycle has no effect, and that record never retires.
- R10: After reset the queue is empty: `free_cnt`=16, `ret_valid`=0, the flush and exception outputs are low, and `alloc_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alloc_valid | input | 3 | Allocation request, one bit per lane |
| alloc_is_br | input | 3 | Lane holds a branch |
| alloc_ready | output | 1 | All requested lanes are accepted at the next edge |
| alloc_tag | output | 4 | Tag given to the first valid lane |
| fin_valid | input | 3 | Finish report, one bit per report port |
| fin_tag | input | 3x4 | Tag of each finish report |
| fin_exc | input | 3 | Finished record carries a fault |
| br_valid | input | 1 | Branch outcome report |
| br_tag | input | 4 | Tag of the reported branch |
| br_mispredict | input | 1 | Reported branch was mispredicted |
| ret_valid | output | 3 | Retire lanes, a run from bit 0 |
| ret_tag | output | 4 | Tag retiring on lane 0 |
| free_cnt | output | 5 | Empty slots available to dispatch |
| exc_valid | output | 1 | Oldest record faulted; queue emptied |
| flush_valid | output | 1 | Flush request for the front end |
| flush_all | output | 1 | Flush covers the whole queue |
| flush_tag | output | 4 | Boundary tag of the flush |

## Verification
A lost or doubled pointer update shows at `free_cnt` on the very next sample, and at `alloc_tag` on the next accepted allocation. A wrong finished flag or a slot-index slip shows at `ret_valid` and `ret_tag` in the cycle right after the report. A flush that cuts at the wrong distance leaves `free_cnt` off by the miscounted records one cycle after the report. A stale unresolved-branch count shows only when a branch request is next refused or accepted, so the bench probes `alloc_ready` right at the limit.

// File: rtl/cq_pkg.sv
package cq_pkg;
  // State kept per slot.
  typedef struct packed {
    logic vld;    // slot holds a live record
    logic done;   // execution reported back
    logic exc;    // reported with a fault
    logic is_br;  // record is a branch
    logic unres;  // branch outcome not yet reported
  } cq_entry_t;
endpackage

// File: rtl/cq_entries.sv
module cq_entries
  import cq_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int LANES     = 3,
  parameter int FIN_PORTS = 3,
  parameter int TAG_W     = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [LANES-1:0]                    wr_en,
  input  logic [LANES-1:0][TAG_W-1:0]         wr_slot,
  input  logic [LANES-1:0]                    wr_br,
  input  logic [FIN_PORTS-1:0]                fin_en,
  input  logic [FIN_PORTS-1:0][TAG_W-1:0]     fin_slot,
  input  logic [FIN_PORTS-1:0]                fin_exc,
  input  logic                                br_en,
  input  logic [TAG_W-1:0]                    br_slot,
  input  logic [DEPTH-1:0]                    kill,
  input  logic [DEPTH-1:0]                    drop,
  output cq_entry_t [DEPTH-1:0]               ent
);

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    cq_entry_t q;
    logic a_hit, a_br, f_hit, f_exc, b_hit;

    always_comb begin
      a_hit = 1'b0;
      a_br  = 1'b0;
      for (int l = 0; l < LANES; l++) begin
        if (wr_en[l] && wr_slot[l] == TAG_W'(s)) begin
          a_hit = 1'b1;
          a_br  = wr_br[l];
        end
      end
      f_hit = 1'b0;
      f_exc = 1'b0;
      for (int p = 0; p < FIN_PORTS; p++) begin
        if (fin_en[p] && fin_slot[p] == TAG_W'(s)) begin
          f_hit = 1'b1;
          f_exc = f_exc | fin_exc[p];
        end
      end
      b_hit = br_en && (br_slot == TAG_W'(s));
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= '0;
      end else if (kill[s] || drop[s]) begin
        q.vld <= 1'b0;
      end else if (a_hit) begin
        q.vld   <= 1'b1;
        q.done  <= 1'b0;
        q.exc   <= 1'b0;
        q.is_br <= a_br;
        q.unres <= a_br;
      end else if (q.vld) begin
        if (f_hit || b_hit) q.done <= 1'b1;
        if (f_hit) q.exc <= q.exc | f_exc;
        if (b_hit) q.unres <= 1'b0;
      end
    end

    assign ent[s] = q;
  end

endmodule

// File: rtl/cq_retire_sel.sv
module cq_retire_sel #(
  parameter int DEPTH = 16,
  parameter int LANES = 3,
  parameter int TAG_W = 4,
  parameter int PTR_W = 5
) (
  input  logic [DEPTH-1:0] done_vec,
  input  logic [DEPTH-1:0] exc_vec,
  input  logic [TAG_W-1:0] head_tag,
  input  logic [PTR_W-1:0] occ,
  output logic [LANES-1:0] ret_valid,
  output logic [PTR_W-1:0] ret_cnt,
  output logic             head_exc
);

  always_comb begin
    logic             run;
    logic             ok;
    logic [TAG_W-1:0] slot;
    run     = 1'b1;
    ret_cnt = '0;
    for (int i = 0; i < LANES; i++) begin
      slot = head_tag + TAG_W'(i);
      ok   = run && (PTR_W'(i) < occ) && done_vec[slot] && !exc_vec[slot];
      ret_valid[i] = ok;
      if (ok) ret_cnt = ret_cnt + PTR_W'(1);
      run = ok;
    end
    head_exc = (occ != '0) && done_vec[head_tag] && exc_vec[head_tag];
  end

endmodule

// File: rtl/cq_alloc_gate.sv
module cq_alloc_gate #(
  parameter int LANES  = 3,
  parameter int MAX_BR = 3,
  parameter int TAG_W  = 4,
  parameter int CNT_W  = 5
) (
  input  logic [LANES-1:0]            req,
  input  logic [LANES-1:0]            req_br,
  input  logic [CNT_W-1:0]            free_cnt,
  input  logic [CNT_W-1:0]            br_pending,
  input  logic                        block,
  output logic                        ready,
  output logic                        fire,
  output logic [LANES-1:0][TAG_W-1:0] lane_off
);

  always_comb begin
    int n;
    int nb;
    n  = 0;
    nb = 0;
    for (int l = 0; l < LANES; l++) begin
      lane_off[l] = TAG_W'(n);
      if (req[l]) n = n + 1;
      if (req[l] && req_br[l]) nb = nb + 1;
    end
    ready = !block && (n <= int'(free_cnt)) && (int'(br_pending) + nb <= MAX_BR);
    fire  = ready && (|req);
  end

endmodule

// File: rtl/completion_queue.sv
module completion_queue
  import cq_pkg::*;
#(
  parameter int  DEPTH     = 16,
  parameter int  LANES     = 3,
  parameter int  FIN_PORTS = 3,
  parameter int  MAX_BR    = 3,
  localparam int TAG_W     = $clog2(DEPTH),
  localparam int PTR_W     = TAG_W + 1,
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [LANES-1:0]                alloc_valid,
  input  logic [LANES-1:0]                alloc_is_br,
  output logic                            alloc_ready,
  output logic [TAG_W-1:0]                alloc_tag,
  input  logic [FIN_PORTS-1:0]            fin_valid,
  input  logic [FIN_PORTS-1:0][TAG_W-1:0] fin_tag,
  input  logic [FIN_PORTS-1:0]            fin_exc,
  input  logic                            br_valid,
  input  logic [TAG_W-1:0]                br_tag,
  input  logic                            br_mispredict,
  output logic [LANES-1:0]                ret_valid,
  output logic [TAG_W-1:0]                ret_tag,
  output logic [CNT_W-1:0]                free_cnt,
  output logic                            exc_valid,
  output logic                            flush_valid,
  output logic                            flush_all,
  output logic [TAG_W-1:0]                flush_tag
);

  // Pointers carry one wrap bit above the slot index.
  logic [PTR_W-1:0] head_q, tail_q, occ;
  logic [TAG_W-1:0] head_tag, tail_tag, dist_br;

  cq_entry_t [DEPTH-1:0]        ent;
  logic [DEPTH-1:0]             done_vec, exc_vec, kill, drop;
  logic [CNT_W-1:0]             br_pending;
  logic [PTR_W-1:0]             ret_cnt;
  logic                         head_exc, misp, fire, gate_ready;
  logic [LANES-1:0][TAG_W-1:0]  lane_off, wr_slot;
  logic [LANES-1:0]             wr_en;

  logic             exc_q, flush_q, flush_all_q;
  logic [TAG_W-1:0] flush_tag_q;

  assign head_tag = head_q[TAG_W-1:0];
  assign tail_tag = tail_q[TAG_W-1:0];
  assign occ      = tail_q - head_q;
  assign free_cnt = CNT_W'(DEPTH) - CNT_W'(occ);

  always_comb begin
    br_pending = '0;
    for (int s = 0; s < DEPTH; s++) begin
      done_vec[s] = ent[s].done;
      exc_vec[s]  = ent[s].exc;
      if (ent[s].vld && ent[s].is_br && ent[s].unres) br_pending = br_pending + CNT_W'(1);
    end
  end

  cq_retire_sel #(
    .DEPTH(DEPTH), .LANES(LANES), .TAG_W(TAG_W), .PTR_W(PTR_W)
  ) u_sel (
    .done_vec (done_vec),
    .exc_vec  (exc_vec),
    .head_tag (head_tag),
    .occ      (occ),
    .ret_valid(ret_valid),
    .ret_cnt  (ret_cnt),
    .head_exc (head_exc)
  );

  // Mispredict applies only to a live branch and loses to a head fault.
  assign misp    = br_valid && br_mispredict && ent[br_tag].vld && !head_exc;
  assign dist_br = br_tag - head_tag;

  always_comb begin
    logic [TAG_W-1:0] ds;
    kill = '0;
    for (int s = 0; s < DEPTH; s++) begin
      ds = TAG_W'(s) - head_tag;
      if (head_exc) kill[s] = ent[s].vld;
      else if (misp && ent[s].vld && ds > dist_br) kill[s] = 1'b1;
    end
    drop = '0;
    for (int i = 0; i < LANES; i++) begin
      if (ret_valid[i]) drop[head_tag + TAG_W'(i)] = 1'b1;
    end
  end

  cq_alloc_gate #(
    .LANES(LANES), .MAX_BR(MAX_BR), .TAG_W(TAG_W), .CNT_W(CNT_W)
  ) u_gate (
    .req       (alloc_valid),
    .req_br    (alloc_is_br),
    .free_cnt  (free_cnt),
    .br_pending(br_pending),
    .block     (head_exc || misp),
    .ready     (gate_ready),
    .fire      (fire),
    .lane_off  (lane_off)
  );

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      wr_slot[l] = tail_tag + lane_off[l];
      wr_en[l]   = fire && alloc_valid[l];
    end
  end

  cq_entries #(
    .DEPTH(DEPTH), .LANES(LANES), .FIN_PORTS(FIN_PORTS), .TAG_W(TAG_W)
  ) u_ent (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_slot (wr_slot),
    .wr_br   (alloc_is_br),
    .fin_en  (fin_valid),
    .fin_slot(fin_tag),
    .fin_exc (fin_exc),
    .br_en   (br_valid),
    .br_slot (br_tag),
    .kill    (kill),
    .drop    (drop),
    .ent     (ent)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_q + ret_cnt;
      if (head_exc)  tail_q <= head_q;
      else if (misp) tail_q <= head_q + PTR_W'(dist_br) + PTR_W'(1);
      else if (fire) tail_q <= tail_q + PTR_W'(lane_off[LANES-1]) + PTR_W'(alloc_valid[LANES-1]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_q       <= 1'b0;
      flush_q     <= 1'b0;
      flush_all_q <= 1'b0;
      flush_tag_q <= '0;
    end else begin
      exc_q       <= head_exc;
      flush_q     <= head_exc || misp;
      flush_all_q <= head_exc;
      flush_tag_q <= head_exc ? head_tag : br_tag;
    end
  end

  assign alloc_ready = gate_ready;
  assign alloc_tag   = tail_tag;
  assign ret_tag     = head_tag;
  assign exc_valid   = exc_q;
  assign flush_valid = flush_q;
  assign flush_all   = flush_all_q;
  assign flush_tag   = flush_tag_q;

endmodule

// File: rtl/cq_checker.sv
module cq_checker #(
  parameter int DEPTH  = 16,
  parameter int LANES  = 3,
  parameter int MAX_BR = 3,
  parameter int TAG_W  = 4,
  parameter int CNT_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] alloc_valid,
  input logic             alloc_ready,
  input logic             br_valid,
  input logic [TAG_W-1:0] br_tag,
  input logic             br_mispredict,
  input logic [LANES-1:0] ret_valid,
  input logic [CNT_W-1:0] free_cnt,
  input logic             exc_valid,
  input logic             flush_valid,
  input logic             flush_all,
  input logic [TAG_W-1:0] flush_tag,
  input logic [CNT_W-1:0] br_pending
);

  // R1
  a_r1_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= CNT_W'(DEPTH));

  // R3
  a_r3_ret_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    ((ret_valid + LANES'(1)) & ret_valid) == '0);

  // R2
  a_r2_no_ret_before_exc: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> $past(ret_valid) == '0);

  // R7
  a_r7_exc_empties: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> flush_valid && flush_all && free_cnt == CNT_W'(DEPTH));

  // R4
  a_r4_misp_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid && !flush_all) |-> ($past(br_valid && br_mispredict) && flush_tag == $past(br_tag)));

  // R6
  a_r6_ready_room: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ready |-> $countones(alloc_valid) <= int'(free_cnt));

  // R8
  a_r8_br_limit: assert property (@(posedge clk) disable iff (!rst_n)
    br_pending <= CNT_W'(MAX_BR));

endmodule

bind completion_queue cq_checker #(
  .DEPTH(DEPTH), .LANES(LANES), .MAX_BR(MAX_BR), .TAG_W(TAG_W), .CNT_W(CNT_W)
) u_cq_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .alloc_valid  (alloc_valid),
  .alloc_ready  (alloc_ready),
  .br_valid     (br_valid),
  .br_tag       (br_tag),
  .br_mispredict(br_mispredict),
  .ret_valid    (ret_valid),
  .free_cnt     (free_cnt),
  .exc_valid    (exc_valid),
  .flush_valid  (flush_valid),
  .flush_all    (flush_all),
  .flush_tag    (flush_tag),
  .br_pending   (br_pending)
);

// File: tb/completion_queue_tb.sv
`timescale 1ns/1ps
module completion_queue_tb;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [2:0]       alloc_valid, alloc_is_br, fin_valid, fin_exc;
  logic [2:0][3:0]  fin_tag;
  logic             br_valid, br_mispredict;
  logic [3:0]       br_tag;
  logic             alloc_ready, exc_valid, flush_valid, flush_all;
  logic [3:0]       alloc_tag, ret_tag, flush_tag;
  logic [2:0]       ret_valid;
  logic [4:0]       free_cnt;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  completion_queue u_dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_is_br(alloc_is_br),
    .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .fin_valid(fin_valid), .fin_tag(fin_tag), .fin_exc(fin_exc),
    .br_valid(br_valid), .br_tag(br_tag), .br_mispredict(br_mispredict),
    .ret_valid(ret_valid), .ret_tag(ret_tag), .free_cnt(free_cnt),
    .exc_valid(exc_valid), .flush_valid(flush_valid),
    .flush_all(flush_all), .flush_tag(flush_tag)
  );

  // Row: {finish mask for tags 2..0, expected retire mask}
  localparam logic [5:0] VEC [0:7] = '{
    {3'b000, 3'b000}, {3'b001, 3'b001}, {3'b010, 3'b000}, {3'b011, 3'b011},
    {3'b100, 3'b000}, {3'b101, 3'b001}, {3'b110, 3'b000}, {3'b111, 3'b111}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    alloc_valid = '0; alloc_is_br = '0; fin_valid = '0; fin_exc = '0;
    fin_tag = '0; br_valid = 1'b0; br_tag = '0; br_mispredict = 1'b0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    do_reset();
    // R10 reset state
    chk("R10 free", free_cnt, 16);
    chk("R10 ret", ret_valid, 0);
    chk("R10 flush", flush_valid, 0);
    chk("R10 exc", exc_valid, 0);
    chk("R10 ready", alloc_ready, 1);

    // R2 R3: finish patterns over three fresh records
    for (int r = 0; r < 8; r++) begin
      do_reset();
      alloc_valid = 3'b111;
      tick();
      idle();
      fin_valid = VEC[r][5:3];
      fin_tag   = {4'd2, 4'd1, 4'd0};
      tick();
      idle();
      chk("R2 retire run", ret_valid, VEC[r][2:0]);
      chk("R1 free after alloc", free_cnt, 13);
    end

    // R1 R6: fill to capacity
    do_reset();
    alloc_valid = 3'b111;
    repeat (5) tick();
    alloc_valid = 3'b001;
    tick();
    chk("R1 full", free_cnt, 0);
    #1 chk("R6 ready when full", alloc_ready, 0);
    idle();
    // R2: younger finishes do not retire ahead of tag 0
    for (int g = 0; g < 5; g++) begin
      fin_valid = 3'b111;
      fin_tag   = {4'(13 - 3*g), 4'(14 - 3*g), 4'(15 - 3*g)};
      tick();
      chk("R2 blocked by head", ret_valid, 0);
    end
    fin_valid = 3'b001; fin_tag = '0;
    tick();
    idle();
    // R3: three per cycle, tags in order
    for (int k = 0; k < 6; k++) begin
      chk("R3 lanes", ret_valid, (k == 5) ? 1 : 7);
      chk("R3 tag", ret_tag, (3*k) % 16);
      tick();
    end
    chk("R1 drained", free_cnt, 16);
    chk("R5 tag wrap", alloc_tag, 0);
    // R5: partial lanes pack onto consecutive tags
    alloc_valid = 3'b101;
    tick();
    idle();
    chk("R5 two lanes", alloc_tag, 2);
    chk("R1 two used", free_cnt, 14);

    // R7: fault at the oldest record after one good retire
    do_reset();
    alloc_valid = 3'b111;
    tick();
    idle();
    fin_valid = 3'b011; fin_tag = {4'd0, 4'd1, 4'd0}; fin_exc = 3'b010;
    tick();
    idle();
    chk("R2 good head retires", ret_valid, 1);
    chk("R7 no early exc", exc_valid, 0);
    tick();
    chk("R7 no retire at fault", ret_valid, 0);
    chk("R1 after one retire", free_cnt, 14);
    tick();
    chk("R7 exc pulse", exc_valid, 1);
    chk("R7 flush all", flush_all, 1);
    chk("R7 flush tag", flush_tag, 1);
    chk("R7 emptied", free_cnt, 16);
    tick();
    chk("R7 one cycle", exc_valid, 0);

    // R4 R9: mispredict with a same-cycle finish for a flushed record
    do_reset();
    alloc_valid = 3'b111; alloc_is_br = 3'b001;
    tick();
    alloc_is_br = 3'b000;
    tick();
    chk("R1 six held", free_cnt, 10);
    idle();
    br_valid = 1'b1; br_tag = 4'd0; br_mispredict = 1'b1;
    fin_valid = 3'b001; fin_tag = {4'd0, 4'd0, 4'd2};
    alloc_valid = 3'b001;
    #1 chk("R6 ready during mispredict", alloc_ready, 0);
    tick();
    idle();
    chk("R4 flush", flush_valid, 1);
    chk("R4 not all", flush_all, 0);
    chk("R4 boundary", flush_tag, 0);
    chk("R4 younger gone", free_cnt, 15);
    chk("R4 branch finished", ret_valid, 1);
    tick();
    chk("R9 flushed finish ignored", ret_valid, 0);
    chk("R9 empty", free_cnt, 16);

    // R8: unresolved branch limit
    do_reset();
    alloc_valid = 3'b111; alloc_is_br = 3'b111;
    tick();
    alloc_valid = 3'b001; alloc_is_br = 3'b001;
    #1 chk("R8 fourth branch refused", alloc_ready, 0);
    alloc_is_br = 3'b000;
    #1 chk("R8 plain accepted", alloc_ready, 1);
    tick();
    idle();
    br_valid = 1'b1; br_tag = 4'd1;
    tick();
    idle();
    alloc_valid = 3'b001; alloc_is_br = 3'b001;
    #1 chk("R8 room after resolve", alloc_ready, 1);
    idle();

    summary();
  end

endmodule